// File: doc/BRIEF.md
# RTC Serial Transaction Sequencer

This block sits between a CPU register port and an external real-time clock chip. It runs one half-duplex serial transfer for each command code the CPU writes. The command code selects three things: the command byte placed on the wire, whether the payload goes out or comes in, and how many payload bytes follow. Payload moves through a single one-byte data register. A status register shows a busy flag, a data-needed flag and the current command nibble, so firmware can feed or drain each byte at its own pace.

The serial clock advances only on cycles that carry a slow tick enable from the system (nominally 384 kHz). Each bit takes two ticks: a falling half and a rising half. Chip select stays high for the whole transfer. When a transfer finishes normally, the block stops driving clock edges. When firmware writes a stop code instead, the transfer state is dropped at once but the clock keeps toggling, so a stop is not a clean abort.

Top module: `rtc_xact_ctrl`

## Requirements
- R1: After a synchronous reset, status reads 0x00 and data reads 0x00. Chip select is low, and the serial clock and serial output are both high.
- R2: Every command write copies its low nibble into status bits 3:0. The status layout is: bit 7 data-needed, bit 4 busy, bits 6:5 zero. A code starts a transfer only when bits 7:5 are zero, bit 4 is one and the nibble is 0x0 to 0xB. A starting code sets busy and chip select on the next cycle. Any other code starts nothing and drives no byte on the wire.
- R3: The first byte on the wire is 0x60 OR the command nibble. Every byte goes least significant bit first. The serial output changes only together with a falling serial-clock edge and is stable at each rising edge. The serial clock changes only on tick cycles.
- R4: The nibble selects the payload. Nibble 0 or 1: none. 2: send 1 byte. 3: receive 1. 4: send 7. 5: receive 7. 6: send 3. 7: receive 3. 8 or A: send 2. 9 or B: receive 2. During a received byte the serial output holds ones.
- R5: A single-byte send transmits whatever the data register already holds, straight after the command byte, and never raises data-needed.
- R6: In a multi-byte send, the first payload byte comes from the data register without waiting. Before each later byte the block raises data-needed (status 0x90 OR nibble) and holds until the CPU writes the data register. That write clears data-needed on the next cycle and becomes the next byte sent.
- R7: Each received byte lands in the data register. After every received byte except the last, data-needed rises and the block holds until a data-register read strobe, which clears data-needed. The last byte is valid once busy clears, and data-needed stays low for it.
- R8: While waiting for the CPU, and after a normal completion, the serial clock rests high and does not toggle. Chip select is low after completion.
- R9: A non-starting code written during a transfer clears busy, data-needed and chip select on the next cycle. The serial clock then keeps toggling on every tick until a later valid transfer completes. A tick that lands in the same cycle as the stop write still toggles the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse that advances the serial clock by half a bit |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command code |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data register write value |
| dat_rd | input | 1 | Data register read strobe (acknowledges a received byte) |
| status_o | output | 8 | Status: data-needed, zeros, busy, command nibble |
| data_o | output | 8 | Data register contents |
| rtc_cs | output | 1 | Chip select to the clock chip |
| rtc_sck | output | 1 | Serial clock, resting high |
| rtc_sdo | output | 1 | Serial data to the clock chip |
| rtc_sdi | input | 1 | Serial data from the clock chip |

## Verification
The hazardous overlap is a stop-code write that lands on the same clock as a serial tick in the middle of a byte. Two things want that cycle: the register port clearing the transfer, and the shifter stepping the clock. The bench provokes it by halting its free-running tick generator and then driving the stop write and a single forced tick in one cycle. It judges the result at the ports. Busy and chip select must be low, and the serial clock must show the edge that tick caused. After that, the clock must keep running on later ticks until a fresh valid transfer completes and silences it.

// File: rtl/rtc_xact_pkg.sv
package rtc_xact_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_PAY,
    PH_WAIT
  } phase_e;

  // Payload byte count selected by the command nibble.
  function automatic logic [2:0] payload_len(input logic [3:0] nib);
    case (nib)
      4'h2, 4'h3:               return 3'd1;
      4'h4, 4'h5:               return 3'd7;
      4'h6, 4'h7:               return 3'd3;
      4'h8, 4'h9, 4'hA, 4'hB:   return 3'd2;
      default:                  return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_xact_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3,
  parameter logic [BYTE_W-1:0] CMD_BASE = BYTE_W'(8'h60)
) (
  input  logic [7:0]        code,
  output logic              ok,
  output logic              rx,
  output logic [LEN_W-1:0]  len,
  output logic [BYTE_W-1:0] cmd_byte
);

  localparam int PAD_W = BYTE_W - 4;

  always_comb begin
    ok       = (code[7:5] == 3'b000) && code[4] && (code[3:0] <= 4'hB);
    rx       = code[0];
    len      = LEN_W'(payload_len(code[3:0]));
    cmd_byte = CMD_BASE | {{PAD_W{1'b0}}, code[3:0]};
  end

endmodule

// File: rtl/rtc_bit_shifter.sv
module rtc_bit_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic              kill,
  input  logic              free_run,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              half;
  logic              shifting;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck       <= 1'b1;
      sdo       <= 1'b1;
      half      <= 1'b0;
      shifting  <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        shreg    <= load_byte;
        bit_cnt  <= '0;
        half     <= 1'b0;
        shifting <= 1'b1;
      end else if (kill) begin
        shifting <= 1'b0;
        half     <= 1'b0;
      end else if (tick && shifting) begin
        if (!half) begin
          sck  <= 1'b0;
          sdo  <= shreg[0];
          half <= 1'b1;
        end else begin
          sck     <= 1'b1;
          half    <= 1'b0;
          rx_byte <= {sdi, rx_byte[BYTE_W-1:1]};
          shreg   <= shreg >> 1;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            shifting  <= 1'b0;
            byte_done <= 1'b1;
          end
        end
      end else if (tick && free_run) begin
        sck <= ~sck;
      end
    end
  end

endmodule

// File: rtl/rtc_xact_fsm.sv
module rtc_xact_fsm
  import rtc_xact_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [3:0]        cmd_nib,
  input  logic              cmd_ok,
  input  logic              cmd_rx,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat_wdata,
  input  logic              dat_rd,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              busy,
  output logic              need,
  output logic [3:0]        nib,
  output logic [BYTE_W-1:0] dreg,
  output logic              free_run,
  output logic              load,
  output logic              kill,
  output logic [BYTE_W-1:0] load_byte
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_e           phase;
  logic             dir_rx;
  logic             relay;
  logic [LEN_W-1:0] left;

  assign free_run = relay & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      busy      <= 1'b0;
      need      <= 1'b0;
      nib       <= '0;
      dreg      <= '0;
      relay     <= 1'b0;
      dir_rx    <= 1'b0;
      left      <= '0;
      load      <= 1'b0;
      kill      <= 1'b0;
      load_byte <= '0;
    end else begin
      load <= 1'b0;
      kill <= 1'b0;
      if (dat_wr) dreg <= dat_wdata;
      if (cmd_wr) begin
        nib  <= cmd_nib;
        kill <= 1'b1;
        need <= 1'b0;
        if (cmd_ok) begin
          busy      <= 1'b1;
          relay     <= 1'b1;
          dir_rx    <= cmd_rx;
          left      <= cmd_len;
          load      <= 1'b1;
          load_byte <= cmd_byte;
          phase     <= PH_CMD;
        end else begin
          busy  <= 1'b0;
          phase <= PH_IDLE;
        end
      end else begin
        case (phase)
          PH_CMD: begin
            if (byte_done) begin
              if (left == '0) begin
                busy  <= 1'b0;
                relay <= 1'b0;
                phase <= PH_IDLE;
              end else begin
                load      <= 1'b1;
                load_byte <= dir_rx ? '1 : dreg;
                phase     <= PH_PAY;
              end
            end
          end
          PH_PAY: begin
            if (byte_done) begin
              left <= left - ONE;
              if (dir_rx) dreg <= rx_byte;
              if (left == ONE) begin
                busy  <= 1'b0;
                relay <= 1'b0;
                phase <= PH_IDLE;
              end else begin
                need  <= 1'b1;
                phase <= PH_WAIT;
              end
            end
          end
          PH_WAIT: begin
            if (!dir_rx && dat_wr) begin
              need      <= 1'b0;
              load      <= 1'b1;
              load_byte <= dat_wdata;
              phase     <= PH_PAY;
            end else if (dir_rx && dat_rd) begin
              need      <= 1'b0;
              load      <= 1'b1;
              load_byte <= '1;
              phase     <= PH_PAY;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rtc_xact_ctrl.sv
module rtc_xact_ctrl
  import rtc_xact_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3,
  parameter logic [BYTE_W-1:0] CMD_BASE = BYTE_W'(8'h60)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_wdata,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat_wdata,
  input  logic              dat_rd,
  output logic [7:0]        status_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              rtc_cs,
  output logic              rtc_sck,
  output logic              rtc_sdo,
  input  logic              rtc_sdi
);

  logic              dec_ok;
  logic              dec_rx;
  logic [LEN_W-1:0]  dec_len;
  logic [BYTE_W-1:0] dec_byte;
  logic              busy;
  logic              need;
  logic [3:0]        nib;
  logic              free_run;
  logic              load;
  logic              kill;
  logic [BYTE_W-1:0] load_byte;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;

  rtc_cmd_decode #(
    .BYTE_W   (BYTE_W),
    .LEN_W    (LEN_W),
    .CMD_BASE (CMD_BASE)
  ) u_dec (
    .code     (cmd_wdata),
    .ok       (dec_ok),
    .rx       (dec_rx),
    .len      (dec_len),
    .cmd_byte (dec_byte)
  );

  rtc_xact_fsm #(
    .BYTE_W (BYTE_W),
    .LEN_W  (LEN_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_nib   (cmd_wdata[3:0]),
    .cmd_ok    (dec_ok),
    .cmd_rx    (dec_rx),
    .cmd_len   (dec_len),
    .cmd_byte  (dec_byte),
    .dat_wr    (dat_wr),
    .dat_wdata (dat_wdata),
    .dat_rd    (dat_rd),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .busy      (busy),
    .need      (need),
    .nib       (nib),
    .dreg      (data_o),
    .free_run  (free_run),
    .load      (load),
    .kill      (kill),
    .load_byte (load_byte)
  );

  rtc_bit_shifter #(
    .BYTE_W (BYTE_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .load      (load),
    .kill      (kill),
    .free_run  (free_run),
    .load_byte (load_byte),
    .sdi       (rtc_sdi),
    .sck       (rtc_sck),
    .sdo       (rtc_sdo),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  assign status_o = {need, 2'b00, busy, nib};
  assign rtc_cs   = busy;

endmodule

// File: rtl/rtc_xact_ctrl_chk.sv
module rtc_xact_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       cmd_wr,
  input logic [7:0] cmd_wdata,
  input logic       need,
  input logic       busy,
  input logic [3:0] nib,
  input logic       rtc_cs,
  input logic       rtc_sck,
  input logic       rtc_sdo
);

  logic code_ok;
  assign code_ok = (cmd_wdata[7:5] == 3'b000) && cmd_wdata[4] && (cmd_wdata[3:0] <= 4'hB);

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && code_ok |=> busy && rtc_cs); // R2

  AST_NIBBLE_TRACKS_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> nib == $past(cmd_wdata[3:0])); // R2

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && !code_ok |=> !busy && !need && !rtc_cs); // R9

  AST_NEED_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    need |-> busy); // R6

  AST_SCK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(rtc_sck)); // R8

  AST_SDO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(rtc_sck) |-> $stable(rtc_sdo)); // R3

endmodule

bind rtc_xact_ctrl rtc_xact_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .cmd_wr    (cmd_wr),
  .cmd_wdata (cmd_wdata),
  .need      (status_o[7]),
  .busy      (status_o[4]),
  .nib       (status_o[3:0]),
  .rtc_cs    (rtc_cs),
  .rtc_sck   (rtc_sck),
  .rtc_sdo   (rtc_sdo)
);

// File: tb/rtc_xact_ctrl_bench.sv
module rtc_xact_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic       dat_rd = 1'b0;
  logic [7:0] status_o;
  logic [7:0] data_o;
  logic       rtc_cs, rtc_sck, rtc_sdo;
  logic       rtc_sdi = 1'b1;
  logic       tick_on = 1'b1;
  logic       tick_force = 1'b0;
  logic [1:0] tcnt = '0;
  logic       tick_en;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  always @(negedge clk) tcnt <= tcnt + 2'd1;
  assign tick_en = (tick_on && tcnt == 2'd0) || tick_force;

  rtc_xact_ctrl u_rtc_xact_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .dat_wr    (dat_wr),
    .dat_wdata (dat_wdata),
    .dat_rd    (dat_rd),
    .status_o  (status_o),
    .data_o    (data_o),
    .rtc_cs    (rtc_cs),
    .rtc_sck   (rtc_sck),
    .rtc_sdo   (rtc_sdo),
    .rtc_sdi   (rtc_sdi)
  );

  // Wire monitor: collects bytes seen by the clock chip, LSB first at rising edges.
  logic [7:0] mon_log [64];
  logic [7:0] mon_sh = '0;
  int         mon_b = 0;
  int         mon_n = 0;
  always @(posedge rtc_sck or negedge rtc_cs) begin
    if (!rtc_cs) begin
      mon_b = 0;
    end else begin
      mon_sh = {rtc_sdo, mon_sh[7:1]};
      mon_b++;
      if (mon_b == 8) begin
        mon_log[mon_n % 64] = mon_sh;
        mon_n++;
        mon_b = 0;
      end
    end
  end

  // Clock chip model: drives payload bits on falling edges.
  logic [7:0] rx_src [8];
  int         rx_k = 0;
  int         rx_base = 0;
  always @(negedge rtc_sck) begin
    if (rtc_cs) begin
      int rel;
      rel = rx_k - rx_base;
      if ((rel >> 3) == 0) rtc_sdi = 1'b1;
      else rtc_sdi = rx_src[((rel >> 3) - 1) % 8][rel & 7];
      rx_k++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wdat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic rdat();
    @(negedge clk); dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
  endtask

  task automatic wait_end(output bit saw_need);
    saw_need = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (!status_o[4]) break;
      if (status_o[7]) saw_need = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic wait_need();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (status_o[7] || !status_o[4]) break;
    end
  endtask

  task automatic sck_quiet(input string req, input int cycles);
    logic s;
    bit moved;
    s = rtc_sck;
    moved = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (rtc_sck !== s) moved = 1'b1;
    end
    chk(!moved && s === 1'b1, req, "sck resting high", {moved, s}, 1);
  endtask

  task automatic t_reset();
    chk(status_o === 8'h00, "R1", "status", status_o, 8'h00);
    chk(data_o === 8'h00, "R1", "data", data_o, 8'h00);
    chk(rtc_cs === 1'b0 && rtc_sck === 1'b1 && rtc_sdo === 1'b1, "R1", "cs/sck/sdo",
        {rtc_cs, rtc_sck, rtc_sdo}, 3'b011);
  endtask

  task automatic t_cmd_only(input logic [7:0] code);
    int base;
    bit sn;
    base = mon_n;
    cmd(code);
    chk(status_o[4] === 1'b1 && rtc_cs === 1'b1, "R2", "start busy/cs", status_o, 8'h10 | code[3:0]);
    wait_end(sn);
    chk(mon_n - base == 1, "R4", "byte count", mon_n - base, 1);
    chk(mon_log[base % 64] === (8'h60 | code[3:0]), "R3", "command byte", mon_log[base % 64], 8'h60 | code[3:0]);
    chk(status_o === {4'h0, code[3:0]} && rtc_cs === 1'b0, "R2", "status after end", status_o, code[3:0]);
    sck_quiet("R8", 40);
  endtask

  task automatic t_single_send();
    int base;
    bit sn;
    wdat(8'hA5);
    base = mon_n;
    cmd(8'h12);
    wait_end(sn);
    chk(!sn, "R5", "data-needed raised", sn, 0);
    chk(mon_n - base == 2, "R4", "byte count 0x12", mon_n - base, 2);
    chk(mon_log[base % 64] === 8'h62, "R3", "command byte 0x12", mon_log[base % 64], 8'h62);
    chk(mon_log[(base + 1) % 64] === 8'hA5, "R5", "payload", mon_log[(base + 1) % 64], 8'hA5);
  endtask

  task automatic t_single_recv();
    int base;
    bit sn;
    rx_src[0] = 8'h3C;
    rx_base = rx_k;
    base = mon_n;
    cmd(8'h13);
    wait_end(sn);
    chk(!sn && data_o === 8'h3C, "R7", "single receive", data_o, 8'h3C);
    chk(mon_n - base == 2 && mon_log[base % 64] === 8'h63, "R3", "command byte 0x13", mon_log[base % 64], 8'h63);
    chk(mon_log[(base + 1) % 64] === 8'hFF, "R4", "sdo ones while receiving", mon_log[(base + 1) % 64], 8'hFF);
  endtask

  task automatic t_multi_send(input logic [7:0] code, input int n, input logic [7:0] b [7]);
    int base;
    bit sn;
    wdat(b[0]);
    base = mon_n;
    cmd(code);
    for (int i = 1; i < n; i++) begin
      wait_need();
      chk(status_o === (8'h90 | code[3:0]), "R6", "need status", status_o, 8'h90 | code[3:0]);
      if (i == 1) sck_quiet("R8", 24);
      wdat(b[i]);
      chk(status_o[7] === 1'b0, "R6", "need cleared by write", status_o, 8'h10 | code[3:0]);
    end
    wait_end(sn);
    chk(mon_n - base == n + 1, "R4", "send byte count", mon_n - base, n + 1);
    chk(mon_log[base % 64] === (8'h60 | code[3:0]), "R3", "send command byte", mon_log[base % 64], 8'h60 | code[3:0]);
    for (int i = 0; i < n; i++)
      chk(mon_log[(base + 1 + i) % 64] === b[i], "R6", "sent payload", mon_log[(base + 1 + i) % 64], b[i]);
  endtask

  task automatic t_multi_recv(input logic [7:0] code, input int n, input logic [7:0] b [7]);
    bit sn;
    for (int i = 0; i < n; i++) rx_src[i] = b[i];
    rx_base = rx_k;
    cmd(code);
    for (int i = 0; i < n - 1; i++) begin
      wait_need();
      chk(status_o === (8'h90 | code[3:0]), "R7", "receive need status", status_o, 8'h90 | code[3:0]);
      chk(data_o === b[i], "R7", "received byte", data_o, b[i]);
      if (i == 0) sck_quiet("R8", 24);
      rdat();
      chk(status_o[7] === 1'b0, "R7", "need cleared by read", status_o, 8'h10 | code[3:0]);
    end
    wait_end(sn);
    chk(!sn && data_o === b[n - 1], "R7", "last received byte", data_o, b[n - 1]);
    chk(rtc_cs === 1'b0, "R8", "cs low after receive", rtc_cs, 0);
  endtask

  task automatic t_invalid();
    int base;
    base = mon_n;
    cmd(8'h1C);
    chk(status_o === 8'h0C && rtc_cs === 1'b0, "R2", "code 0x1C", status_o, 8'h0C);
    cmd(8'h05);
    chk(status_o === 8'h05, "R2", "code 0x05", status_o, 8'h05);
    cmd(8'h30);
    chk(status_o === 8'h00, "R2", "code 0x30 high bits", status_o, 8'h00);
    repeat (100) @(negedge clk);
    chk(mon_n == base, "R2", "no wire bytes", mon_n - base, 0);
  endtask

  task automatic t_stop_on_tick();
    logic s0;
    int edges;
    logic prev;
    int base;
    bit sn;
    wdat(8'h11);
    cmd(8'h14);
    repeat (100) @(negedge clk);
    tick_on = 1'b0;
    repeat (2) @(negedge clk);
    s0 = rtc_sck;
    cmd_wr = 1'b1; cmd_wdata = 8'h00; tick_force = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; tick_force = 1'b0;
    chk(status_o === 8'h00 && rtc_cs === 1'b0, "R9", "stop clears", status_o, 8'h00);
    chk(rtc_sck === ~s0, "R9", "coincident tick toggles sck", rtc_sck, ~s0);
    repeat (2) @(negedge clk);
    tick_on = 1'b1;
    edges = 0;
    prev = rtc_sck;
    repeat (64) begin
      @(negedge clk);
      if (rtc_sck !== prev) edges++;
      prev = rtc_sck;
    end
    chk(edges >= 8, "R9", "clock keeps relaying", edges, 16);
    base = mon_n;
    cmd(8'h10);
    wait_end(sn);
    chk(mon_n - base == 1 && mon_log[base % 64] === 8'h60, "R3", "command after stop", mon_log[base % 64], 8'h60);
    sck_quiet("R8", 40);
  endtask

  initial begin
    logic [7:0] sb [7];
    logic [7:0] rb [7];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cmd_only(8'h10);
    t_cmd_only(8'h11);
    t_single_send();
    t_single_recv();
    sb = '{8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00};
    t_multi_send(8'h16, 3, sb);
    sb = '{8'hE1, 8'h5F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    t_multi_send(8'h1A, 2, sb);
    sb = '{8'h01, 8'h80, 8'h7E, 8'hC4, 8'h29, 8'hFF, 8'h36};
    t_multi_send(8'h14, 7, sb);
    rb = '{8'hC3, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    t_multi_recv(8'h19, 2, rb);
    rb = '{8'h0F, 8'hA0, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00};
    t_multi_recv(8'h17, 3, rb);
    rb = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE};
    t_multi_recv(8'h15, 7, rb);
    t_invalid();
    t_stop_on_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule